// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a virtual page to a real page when no block-level mapping covers the address. A request selects one of sixteen segment descriptors by the top four address bits. Two kinds of segment end at once: a direct-store segment, and an instruction fetch from a segment marked no-execute. For any other segment the block derives a protection key. It then hashes the segment's virtual segment id with the page index to locate a group of eight page table entries in memory.

The walker reads the entries one at a time through a single-word memory port. It checks each entry's valid bit, pass bit and tag, and evaluates the protection bits of the first match against the key. If the primary group gives no grant, the walker searches a second group whose address comes from the complemented hash. When an entry is found, the walker sets its referenced bit, and sets its changed bit if a write was granted. The second word is written back only if it changed. The requester receives a result code, the real page number and the read and write permissions, together with a one-cycle done pulse.

Top module: `hpt_walker`

## Requirements
- R1: A segment whose bit 31 is set finishes with result code 4 (direct-store) and makes no memory access. The segment is selected from `seg_regs` bits [32n+31:32n], where n is `vpage[19:16]`.
- R2: An instruction fetch (`is_fetch`=1) from a segment with bit 28 set finishes with result code 3 (no-execute) and makes no memory access. A fetch is treated as a read.
- R3: In the primary pass, the group address is `{tbl_base[31:16],16'h0} | (H & M)`. Here H = `((vsid ^ pidx) & 19'h7FFFF) << 6`, M = `{tbl_base[8:0],16'hFFC0}`, vsid is segment bits [23:0] and pidx is `vpage[15:0]`. Slot i is the word pair at group+8i (first word) and group+8i+4 (second word). A slot matches when first-word bit 31 is 1, bit 6 equals the pass number, and the first word masked by 32'h7FFFFFBF equals `(vsid<<7) | pidx[15:10]`.
- R4: The secondary pass, which uses H2 = `~H & 32'h01FFFFC0` and requires bit 6 = 1, runs only when the primary pass does not end in success.
- R5: The key is 1 when (segment bit 30 is set and `is_user`=0) or (segment bit 29 is set and `is_user`=1), and 0 otherwise. The protection field is second-word bits [1:0] (PP). With key 0, reads are allowed, and writes are allowed unless PP=3. With key 1, PP=0 denies all access, PP=1 or 3 allows reads only, and PP=2 allows reads and writes. A denied access gives result code 2.
- R6: If a second matching slot in a pass differs from the first in bits selected by 32'hFFFFF07B of its second word, that pass reports not-found (code 1) and writes nothing.
- R7: On a found entry, the second word gets bit 8 (referenced) set, and bit 7 (changed) set only for a granted write. It is written back to group+8·slot+4 only when its value changed. This happens even when the access was denied.
- R8: When the changed bit of the found entry remains clear, `perm_wr` is reported as 0.
- R9: The secondary pass result replaces the primary one unless the secondary pass is not-found (code 1).
- R10: On success (code 0), `rpn` carries the found second word's bits [31:12] and `perm_rd` is 1. For every other result, `rpn`, `perm_rd` and `perm_wr` are 0. Outputs hold until the next `done`.
- R11: After reset, `busy`, `done` and `mem_req` are 0. A table search holds `busy` from the cycle after `start` until `done` pulses for one cycle. Read data is expected on `mem_rdata` the cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a translation (sampled when idle) |
| vpage | input | 20 | Virtual address bits [31:12] |
| is_write | input | 1 | Store access |
| is_fetch | input | 1 | Instruction fetch |
| is_user | input | 1 | User-mode access |
| seg_regs | input | 512 | Sixteen 32-bit segment descriptors |
| tbl_base | input | 32 | Page table base and size mask |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after request |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 ok, 1 not-found, 2 protection, 3 no-execute, 4 direct-store |
| rpn | output | 20 | Real page number |
| perm_rd | output | 1 | Read permitted |
| perm_wr | output | 1 | Write permitted |

## Verification
The embedded assertions check properties that must hold on every cycle:
- memory is touched only while busy;
- every write-back carries the referenced bit;
- done never overlaps busy, and each fall of busy coincides with done;
- a success always grants read;
- a no-execute result only follows a fetch.

The bench scenarios check what depends on table contents. These are the group hashing for both passes, the key and protection decoding, and rejection of inconsistent duplicates. They also cover the replacement rule between passes and the exact values and count of write-backs. Each scenario is compared against an independent model of the requirements.

// File: rtl/hpt_walker.sv
module hpt_walker #(
  parameter int GROUP_SLOTS = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [19:0]  vpage,
  input  logic         is_write,
  input  logic         is_fetch,
  input  logic         is_user,
  input  logic [511:0] seg_regs,
  input  logic [31:0]  tbl_base,
  output logic         mem_req,
  output logic         mem_we,
  output logic [31:0]  mem_addr,
  output logic [31:0]  mem_wdata,
  input  logic [31:0]  mem_rdata,
  output logic         busy,
  output logic         done,
  output logic [2:0]   result,
  output logic [19:0]  rpn,
  output logic         perm_rd,
  output logic         perm_wr
);
  localparam int SLOT_W = $clog2(GROUP_SLOTS);
  localparam logic [2:0] RES_OK = 3'd0, RES_NF = 3'd1, RES_PROT = 3'd2,
                         RES_NX = 3'd3, RES_DS = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_RD0, S_RD1, S_EVAL, S_PEND, S_WB, S_NEXT} st_t;
  st_t st;

  logic [23:0]       vsid_q;
  logic [15:0]       pidx_q;
  logic              wr_q, fe_q, key_q, pass_q, found_q, pr_q, pw_q;
  logic [SLOT_W-1:0] idx_q, good_q;
  logic [31:0]       w0_q, keep_q;
  logic [2:0]        pres_q, p0_q;

  wire [31:0] seg_sel = seg_regs[{vpage[19:16], 5'b0} +: 32];
  wire unused_bits = ^{tbl_base[15:9], seg_sel[27:24]};

  wire [18:0] hx    = vsid_q[18:0] ^ {3'b0, pidx_q};
  wire [31:0] h0    = {7'b0, hx, 6'b0};
  wire [31:0] hsel  = pass_q ? (~h0 & 32'h01FFFFC0) : h0;
  wire [31:0] pmask = {7'b0, tbl_base[8:0], 16'hFFC0};
  wire [31:0] grp   = {tbl_base[31:16], 16'h0} | (hsel & pmask);
  wire [31:0] slot_a = grp + {{(29-SLOT_W){1'b0}}, idx_q, 3'b000};
  wire [31:0] good_a = grp + {{(29-SLOT_W){1'b0}}, good_q, 3'b000};
  wire [31:0] ptem  = {1'b0, vsid_q, 7'b0} | {26'b0, pidx_q[15:10]};

  wire       hit   = w0_q[31] && (w0_q[6] == pass_q) && ((w0_q & 32'h7FFFFFBF) == ptem);
  wire [1:0] pp    = mem_rdata[1:0];
  wire       rd_ok = !key_q || (pp != 2'd0);
  wire       wr_ok = key_q ? (pp == 2'd2) : (pp != 2'd3);
  wire       grant = wr_q ? wr_ok : rd_ok;
  wire       clash = ((keep_q ^ mem_rdata) & 32'hFFFFF07B) != 32'h0;
  wire       set_c = wr_q && (pres_q == RES_OK) && !keep_q[7];
  wire [31:0] new_keep = keep_q | 32'h100 | (set_c ? 32'h80 : 32'h0);
  wire [2:0] fin   = (pass_q && pres_q == RES_NF) ? p0_q : pres_q;
  wire       last  = idx_q == SLOT_W'(GROUP_SLOTS - 1);

  assign busy      = st != S_IDLE;
  assign mem_req   = st == S_RD0 || st == S_RD1 || st == S_WB;
  assign mem_we    = st == S_WB;
  assign mem_addr  = st == S_RD1 ? slot_a + 32'd4 : st == S_WB ? good_a + 32'd4 : slot_a;
  assign mem_wdata = keep_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; vsid_q <= '0; pidx_q <= '0; wr_q <= 1'b0; fe_q <= 1'b0;
      key_q <= 1'b0; pass_q <= 1'b0; found_q <= 1'b0; pr_q <= 1'b0; pw_q <= 1'b0;
      idx_q <= '0; good_q <= '0; w0_q <= '0; keep_q <= '0; pres_q <= RES_NF;
      p0_q <= RES_NF; done <= 1'b0; result <= RES_OK; rpn <= '0;
      perm_rd <= 1'b0; perm_wr <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          vsid_q <= seg_sel[23:0];
          pidx_q <= vpage[15:0];
          wr_q   <= is_write && !is_fetch;
          fe_q   <= is_fetch;
          key_q  <= (seg_sel[30] && !is_user) || (seg_sel[29] && is_user);
          pass_q <= 1'b0; idx_q <= '0; found_q <= 1'b0; pres_q <= RES_NF;
          if (seg_sel[31] || (is_fetch && seg_sel[28])) begin
            result <= seg_sel[31] ? RES_DS : RES_NX;
            rpn <= '0; perm_rd <= 1'b0; perm_wr <= 1'b0; done <= 1'b1;
          end else begin
            st <= S_RD0;
          end
        end
        S_RD0: st <= S_RD1;
        S_RD1: begin
          w0_q <= mem_rdata;
          st   <= S_EVAL;
        end
        S_EVAL: begin
          if (hit && found_q && clash) begin
            found_q <= 1'b0;
            pres_q  <= RES_NF;
            st      <= S_PEND;
          end else begin
            if (hit && !found_q) begin
              found_q <= 1'b1; good_q <= idx_q; keep_q <= mem_rdata;
              pres_q  <= grant ? RES_OK : RES_PROT;
              pr_q <= rd_ok; pw_q <= wr_ok;
            end
            if (last) st <= S_PEND;
            else begin
              idx_q <= idx_q + 1'b1;
              st    <= S_RD0;
            end
          end
        end
        S_PEND: begin
          if (found_q) begin
            keep_q <= new_keep;
            if (!keep_q[7] && !set_c) pw_q <= 1'b0;
            st <= (new_keep != keep_q) ? S_WB : S_NEXT;
          end else begin
            pres_q <= RES_NF;
            st     <= S_NEXT;
          end
        end
        S_WB: st <= S_NEXT;
        S_NEXT: begin
          if (!pass_q && pres_q != RES_OK) begin
            p0_q <= pres_q; pass_q <= 1'b1; idx_q <= '0;
            found_q <= 1'b0; pres_q <= RES_NF; st <= S_RD0;
          end else begin
            result  <= fin;
            rpn     <= (fin == RES_OK) ? keep_q[31:12] : 20'h0;
            perm_rd <= (fin == RES_OK) && pr_q;
            perm_wr <= (fin == RES_OK) && pw_q;
            done    <= 1'b1;
            st      <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R11
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);
  // R1
  mem_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> busy);
  // R7
  wb_ref_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> mem_wdata[8]);
  // R10
  ok_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == RES_OK) |-> perm_rd);
  // R2
  nx_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == RES_NX) |-> fe_q);
endmodule

// File: tb/test_hpt_walker.sv
module test_hpt_walker;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [19:0] vpage = '0;
  logic is_write = 1'b0, is_fetch = 1'b0, is_user = 1'b0;
  logic [511:0] seg_regs;
  logic [31:0] tbl_base = 32'h0004_0000;
  logic mem_req, mem_we, busy, done, perm_rd, perm_wr;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [2:0] result;
  logic [19:0] rpn;

  always #5 clk = ~clk;

  hpt_walker i_hpt_walker (.*);

  logic [31:0] seg [16];
  for (genvar n = 0; n < 16; n++) begin : g_seg
    assign seg_regs[n*32 +: 32] = seg[n];
  end

  logic [31:0] mem [logic [31:0]];
  logic [31:0] wlog_a [$], wlog_v [$];
  int checks = 0, fails = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) if (mem_req) begin
    if (mem_we) begin
      mem[mem_addr] = mem_wdata;
      wlog_a.push_back(mem_addr);
      wlog_v.push_back(mem_wdata);
    end else mem_rdata <= rd(mem_addr);
  end

  function automatic logic [31:0] grp_of(input logic [23:0] vs, input logic [15:0] pi, input bit p);
    logic [31:0] h, m;
    h = {7'b0, vs[18:0] ^ {3'b0, pi}, 6'b0};
    if (p) h = ~h & 32'h01FFFFC0;
    m = {7'b0, tbl_base[8:0], 16'hFFC0};
    return {tbl_base[31:16], 16'h0} | (h & m);
  endfunction

  function automatic logic [31:0] ptem_of(input logic [23:0] vs, input logic [15:0] pi);
    return {1'b0, vs, 7'b0} | {26'b0, pi[15:10]};
  endfunction

  task automatic put(input logic [19:0] vp, input bit p, input bit hb, input int slot, input logic [31:0] w1);
    logic [31:0] s, g;
    s = seg[vp[19:16]];
    g = grp_of(s[23:0], vp[15:0], p);
    mem[g + 8*slot] = 32'h8000_0000 | ptem_of(s[23:0], vp[15:0]) | (hb ? 32'h40 : 32'h0);
    mem[g + 8*slot + 4] = w1;
  endtask

  typedef struct {
    logic [2:0] res; logic [19:0] rpn; logic pr, pw; int n;
    logic [31:0] wa0, wv0, wa1, wv1; string tag;
  } exp_t;
  exp_t exp_q [$];

  logic [2:0] m_res; logic [19:0] m_rpn; logic m_pr, m_pw; int m_n;
  logic [31:0] m_wa [2]; logic [31:0] m_wv [2];

  task automatic model(input logic [19:0] vp, input bit wr, input bit fe, input bit us);
    logic [31:0] s, g, w0, w1, k, nk, pt;
    logic [23:0] vs; logic [15:0] pi;
    bit key, found, bad, rok, wok;
    logic [2:0] pres, p0;
    int gi;
    m_n = 0; m_rpn = '0; m_pr = 1'b0; m_pw = 1'b0; m_wa = '{0, 0}; m_wv = '{0, 0};
    s = seg[vp[19:16]];
    if (s[31]) begin m_res = 3'd4; return; end
    if (fe && s[28]) begin m_res = 3'd3; return; end
    if (fe) wr = 1'b0;
    key = (s[30] && !us) || (s[29] && us);
    vs = s[23:0]; pi = vp[15:0]; pt = ptem_of(vs, pi);
    p0 = 3'd1; m_res = 3'd1;
    for (int p = 0; p < 2; p++) begin
      g = grp_of(vs, pi, p[0]); found = 0; bad = 0; pres = 3'd1; gi = 0; k = '0; rok = 0; wok = 0;
      for (int i = 0; i < 8; i++) begin
        w0 = rd(g + 8*i); w1 = rd(g + 8*i + 4);
        if (w0[31] && w0[6] == p[0] && (w0 & 32'h7FFFFFBF) == pt) begin
          if (!found) begin
            found = 1; gi = i; k = w1;
            rok = !key || w1[1:0] != 2'd0;
            wok = key ? (w1[1:0] == 2'd2) : (w1[1:0] != 2'd3);
            pres = (wr ? wok : rok) ? 3'd0 : 3'd2;
          end else if (((k ^ w1) & 32'hFFFFF07B) != 0) begin
            bad = 1; break;
          end
        end
      end
      if (bad || !found) pres = 3'd1;
      else begin
        nk = k | 32'h100;
        if (!k[7]) begin
          if (wr && pres == 3'd0) nk = nk | 32'h80;
          else wok = 0;
        end
        if (nk != k) begin m_wa[m_n] = g + 8*gi + 4; m_wv[m_n] = nk; m_n++; end
      end
      if (pres == 3'd0) begin
        m_res = 3'd0; m_rpn = k[31:12]; m_pr = rok; m_pw = wok; return;
      end
      if (p == 0) p0 = pres;
      else m_res = (pres == 3'd1) ? p0 : pres;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input string what, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  task automatic txn(input logic [19:0] vp, input bit wr, input bit fe, input bit us, input string tag);
    exp_t e;
    model(vp, wr, fe, us);
    e.res = m_res; e.rpn = m_rpn; e.pr = m_pr; e.pw = m_pw; e.n = m_n;
    e.wa0 = m_wa[0]; e.wv0 = m_wv[0]; e.wa1 = m_wa[1]; e.wv1 = m_wv[1]; e.tag = tag;
    wlog_a.delete(); wlog_v.delete();
    exp_q.push_back(e);
    @(negedge clk);
    vpage = vp; is_write = wr; is_fetch = fe; is_user = us; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  always @(negedge clk) if (rst_n && done) begin
    exp_t e;
    if (exp_q.size() == 0) chk(1'b0, "R11", "unexpected done", 1, 0);
    else begin
      e = exp_q.pop_front();
      chk(result == e.res, e.tag, "result", result, e.res);
      chk(rpn == e.rpn, e.tag, "rpn", rpn, e.rpn);
      chk({perm_rd, perm_wr} == {e.pr, e.pw}, e.tag, "perm", {perm_rd, perm_wr}, {e.pr, e.pw});
      chk(wlog_a.size() == e.n, e.tag, "writeback count", wlog_a.size(), e.n);
      if (e.n > 0 && wlog_a.size() > 0)
        chk(wlog_a[0] == e.wa0 && wlog_v[0] == e.wv0, e.tag, "writeback 0", wlog_v[0], e.wv0);
      if (e.n > 1 && wlog_a.size() > 1)
        chk(wlog_a[1] == e.wa1 && wlog_v[1] == e.wv1, e.tag, "writeback 1", wlog_v[1], e.wv1);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int n = 0; n < 16; n++) seg[n] = 32'h0;
    seg[0]  = 32'h0000_0123;
    seg[1]  = 32'h6000_0456;
    seg[2]  = 32'h1000_0789;
    seg[3]  = 32'h4000_0ABC;
    seg[15] = 32'h8000_0000;
    put(20'h0_0001, 0, 0, 3, 32'hABCDE002);
    put(20'h1_0002, 0, 0, 0, 32'h11111000);
    put(20'h1_0003, 0, 0, 7, 32'h22222001);
    put(20'h0_0004, 1, 1, 5, 32'h12345182);
    put(20'h0_0005, 0, 1, 2, 32'h55555002);
    put(20'h0_0006, 0, 0, 1, 32'h66666002);
    put(20'h0_0006, 0, 0, 4, 32'h77777002);
    put(20'h0_0007, 0, 0, 2, 32'h88888002);
    put(20'h0_0007, 0, 0, 6, 32'h88888182);
    put(20'h1_0008, 0, 0, 0, 32'h99999000);
    put(20'h1_0008, 1, 1, 3, 32'hAAAAA002);
    put(20'h3_000A, 0, 0, 4, 32'hBBBBB003);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !mem_req, "R11", "reset outputs", {busy, done, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    txn(20'hF_0001, 0, 0, 0, "R1");
    txn(20'h2_0001, 0, 1, 0, "R2");
    txn(20'h0_0001, 0, 0, 0, "R3");
    txn(20'h0_0001, 0, 0, 0, "R8");
    txn(20'h0_0001, 1, 0, 0, "R7");
    txn(20'h0_0001, 0, 1, 1, "R2");
    txn(20'h1_0002, 0, 0, 0, "R5");
    txn(20'h1_0003, 1, 0, 1, "R5");
    txn(20'h1_0003, 0, 0, 1, "R5");
    txn(20'h0_0004, 1, 0, 0, "R4");
    txn(20'h0_0005, 0, 0, 0, "R3");
    txn(20'h0_0006, 0, 0, 0, "R6");
    txn(20'h0_0007, 1, 0, 0, "R6");
    txn(20'h1_0008, 0, 0, 1, "R9");
    txn(20'h0_0009, 0, 0, 0, "R10");
    txn(20'h3_000A, 1, 0, 1, "R5");
    txn(20'h3_000A, 0, 0, 0, "R10");
    repeat (4) @(negedge clk);
    // R11 idle after the last request
    chk(!busy && !mem_req, "R11", "idle at end", {busy, mem_req}, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule